// File: doc/BRIEF.md
# Flash Access Timing Controller

This block converts requests from an internal bus into the strobe sequence a synchronous flash macro needs. One accepted request runs through four phases. An address-latch pulse comes first, then an equalize/sense pulse, then a programmable number of wait cycles, then one capture cycle. A one-cycle response follows. Active-low chip-enable, output-enable and write-enable frame the access. Three configuration fields set the address-latch width, the equalize width and the wait count, and each field acts on its own phase only. A memory that stands in for the flash sees the same cycle-exact sequence, because only these fields decide the timing.

A read returns 32 or 64 bits, chosen for each request. A program write drives 16 or 32 bits. The configuration fields are copied when a request is accepted, so a configuration write during an access has no effect on that access. An abort input ends the access in whatever cycle it is asserted. The controller is idle on the next cycle, and the next access runs with its normal timing.

Top module: `flt_timing_ctrl`

## Requirements
- R1: After reset all three active-low strobes are high, the latch and equalize pulses are low and req_ready is high. The reset configuration is a latch field of 0, an equalize field of 0 and a wait field of all ones (15 with default widths), so the first read shows its response in cycle 19 after acceptance.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. fl_alat is high from cycle 1 after acceptance for latch field + 1 cycles.
- R3: fl_eq is high for equalize field + 1 cycles. It starts in the cycle right after the last latch cycle.
- R4: After the equalize pulse there are exactly wait field cycles (zero allowed), then one capture cycle. rsp_valid is high for exactly one cycle, in cycle A+E+W+4 after acceptance, where A, E and W are the three field values.
- R5: Changing any one configuration field changes only the length of its own phase. The other phases keep their lengths.
- R6: fl_ce_n is low from the first latch cycle through the capture cycle (A+E+W+3 cycles). On a read, fl_oe_n is low for the same cycles and fl_we_n stays high.
- R7: With req_wide=1, a read returns all 64 bits of fl_rdata sampled in the capture cycle. With req_wide=0, it returns the low 32 bits with the upper 32 bits of rsp_data zero.
- R8: On a program write (req_write=1), fl_oe_n stays high and fl_we_n is low during the equalize and wait phases (E+1+W cycles). fl_wdata carries all 32 bits when req_wide=1, and the low 16 bits zero-extended when req_wide=0. fl_wide follows req_wide.
- R9: req_ready is low from the cycle after acceptance through the response cycle, and is high again in the cycle after it.
- R10: When req_abort is high at an edge during an access, then in the next cycle all strobes are inactive, req_ready is high and no response is given. The next access has exactly the timing given by R2 to R4. Outside an access, req_abort has no effect.
- R11: The configuration fields take effect only at acceptance. A configuration write during an access leaves that access's timing unchanged and applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Writes the three timing fields |
| cfg_alat | input | CW | Latch pulse width minus one |
| cfg_eq | input | CW | Equalize pulse width minus one |
| cfg_wait | input | WW | Wait cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = program write, 0 = read |
| req_wide | input | 1 | Read: 1 = 64 bit; write: 1 = 32 bit |
| req_addr | input | AW | Flash word address |
| req_wdata | input | 32 | Program data |
| req_abort | input | 1 | Cancels the running access |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 64 | Read data |
| fl_addr | output | AW | Address to flash |
| fl_alat | output | 1 | Address-latch pulse |
| fl_eq | output | 1 | Equalize/sense pulse |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_wide | output | 1 | Width select to flash |
| fl_wdata | output | 32 | Program data to flash |
| fl_rdata | input | 64 | Read data from flash |

## Verification
The bench uses the default parameters: AW=20, CW=3 and WW=4. With these widths the latch and equalize pulses run from 1 to 8 cycles and the wait count from 0 to 15. The full reset-time wait of 15 is therefore short enough to run as a test. A three-field set of 2/1/3 is then varied one field at a time, and a wait of zero is also run. Aborts are placed in the latch, equalize and capture phases, and each is followed by a full access to show there is no recovery penalty.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALAT,
    ST_EQ,
    ST_WAIT,
    ST_CAP,
    ST_RDY
  } flt_state_e;
endpackage

// File: rtl/flt_cfg_regs.sv
module flt_cfg_regs #(
  parameter int CW = 3,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_alat,
  input  logic [CW-1:0] cfg_eq,
  input  logic [WW-1:0] cfg_wait,
  output logic [CW-1:0] cur_alat,
  output logic [CW-1:0] cur_eq,
  output logic [WW-1:0] cur_wait
);
  logic [CW-1:0] alat_d, eq_d;
  logic [WW-1:0] wait_d;

  always_comb begin
    alat_d = cur_alat;
    eq_d   = cur_eq;
    wait_d = cur_wait;
    if (cfg_we) begin
      alat_d = cfg_alat;
      eq_d   = cfg_eq;
      wait_d = cfg_wait;
    end
  end

  // reset: shortest pulses, longest wait
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_alat <= '0;
      cur_eq   <= '0;
      cur_wait <= '1;
    end else begin
      cur_alat <= alat_d;
      cur_eq   <= eq_d;
      cur_wait <= wait_d;
    end
  end
endmodule

// File: rtl/flt_seq.sv
module flt_seq
  import flt_pkg::*;
#(
  parameter int CW = 3,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          op_write,
  input  logic [CW-1:0] cfg_alat,
  input  logic [CW-1:0] cfg_eq,
  input  logic [WW-1:0] cfg_wait,
  output logic          idle,
  output logic          fl_alat,
  output logic          fl_eq,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          cap,
  output logic          rsp
);
  localparam int NW = (CW > WW) ? CW : WW;

  flt_state_e    state_q, state_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] snap_e_q;
  logic [WW-1:0] snap_w_q;
  logic          busy;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ALAT;
        cnt_d   = NW'(cfg_alat);
      end
      ST_ALAT: if (cnt_q == '0) begin
        state_d = ST_EQ;
        cnt_d   = NW'(snap_e_q);
      end else begin
        cnt_d = cnt_q - NW'(1);
      end
      ST_EQ: if (cnt_q == '0) begin
        if (snap_w_q == '0) begin
          state_d = ST_CAP;
        end else begin
          state_d = ST_WAIT;
          cnt_d   = NW'(snap_w_q - WW'(1));
        end
      end else begin
        cnt_d = cnt_q - NW'(1);
      end
      ST_WAIT: if (cnt_q == '0) begin
        state_d = ST_CAP;
      end else begin
        cnt_d = cnt_q - NW'(1);
      end
      ST_CAP:  state_d = ST_RDY;
      ST_RDY:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    // cancellation: straight back to idle, counter cleared
    if (abort && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // timing snapshot, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_e_q <= '0;
      snap_w_q <= '0;
    end else if (start && state_q == ST_IDLE) begin
      snap_e_q <= cfg_eq;
      snap_w_q <= cfg_wait;
    end
  end

  always_comb begin
    busy    = (state_q == ST_ALAT) || (state_q == ST_EQ) ||
              (state_q == ST_WAIT) || (state_q == ST_CAP);
    idle    = (state_q == ST_IDLE);
    fl_alat = (state_q == ST_ALAT);
    fl_eq   = (state_q == ST_EQ);
    cap     = (state_q == ST_CAP);
    rsp     = (state_q == ST_RDY);
    fl_ce_n = !busy;
    fl_oe_n = !(busy && !op_write);
    fl_we_n = !(op_write && ((state_q == ST_EQ) || (state_q == ST_WAIT)));
  end
endmodule

// File: rtl/flt_datapath.sv
module flt_datapath #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cap,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [63:0]   fl_rdata,
  output logic          op_write,
  output logic [AW-1:0] fl_addr,
  output logic [31:0]   fl_wdata,
  output logic          fl_wide,
  output logic [63:0]   rsp_data
);
  logic [31:0] wdata_q;
  logic [63:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_addr  <= '0;
      wdata_q  <= '0;
      op_write <= 1'b0;
      fl_wide  <= 1'b0;
    end else if (start) begin
      fl_addr  <= req_addr;
      wdata_q  <= req_wdata;
      op_write <= req_write;
      fl_wide  <= req_wide;
    end
  end

  always_comb begin
    if (!op_write) fl_wdata = '0;
    else if (fl_wide) fl_wdata = wdata_q;
    else fl_wdata = {16'h0000, wdata_q[15:0]};
    if (op_write) rdata_d = '0;
    else if (fl_wide) rdata_d = fl_rdata;
    else rdata_d = {32'h0, fl_rdata[31:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_data <= '0;
    else if (cap) rsp_data <= rdata_d;
  end
endmodule

// File: rtl/flt_timing_ctrl.sv
module flt_timing_ctrl #(
  parameter int AW = 20,
  parameter int CW = 3,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_alat,
  input  logic [CW-1:0] cfg_eq,
  input  logic [WW-1:0] cfg_wait,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic          req_abort,
  output logic          rsp_valid,
  output logic [63:0]   rsp_data,
  output logic [AW-1:0] fl_addr,
  output logic          fl_alat,
  output logic          fl_eq,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          fl_wide,
  output logic [31:0]   fl_wdata,
  input  logic [63:0]   fl_rdata
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          start, cap, op_write, idle;
  logic [CW-1:0] cur_alat, cur_eq;
  logic [WW-1:0] cur_wait;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign req_ready = idle;
  assign start     = req_valid && idle;

  flt_cfg_regs #(.CW(CW), .WW(WW)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we),
    .cfg_alat(cfg_alat), .cfg_eq(cfg_eq), .cfg_wait(cfg_wait),
    .cur_alat(cur_alat), .cur_eq(cur_eq), .cur_wait(cur_wait)
  );

  flt_seq #(.CW(CW), .WW(WW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .abort(req_abort),
    .op_write(op_write), .cfg_alat(cur_alat), .cfg_eq(cur_eq),
    .cfg_wait(cur_wait), .idle(idle), .fl_alat(fl_alat), .fl_eq(fl_eq),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .cap(cap), .rsp(rsp_valid)
  );

  flt_datapath #(.AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_int_n), .start(start), .cap(cap),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_wide(req_wide), .fl_rdata(fl_rdata), .op_write(op_write),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wide(fl_wide),
    .rsp_data(rsp_data)
  );
endmodule

// File: rtl/flt_checker.sv
module flt_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_abort,
  input logic rsp_valid,
  input logic fl_alat,
  input logic fl_eq,
  input logic fl_ce_n,
  input logic fl_oe_n,
  input logic fl_we_n
);
  // R2: an accepted request starts with the latch pulse
  a_r2_accept_starts_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_abort) |=> (fl_alat && !req_ready));

  // R2: the latch pulse only occurs inside chip-enable
  a_r2_latch_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    fl_alat |-> !fl_ce_n);

  // R3: latch and equalize never overlap; equalize follows latch
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_alat && fl_eq));
  a_r3_eq_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_alat && !req_abort) |=> (fl_alat || fl_eq));

  // R4: response is one cycle wide
  a_r4_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6 / R8: output and write enable are exclusive and need chip-enable
  a_r6_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_ce_n);
  a_r8_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  // R9: idle again right after the response
  a_r9_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready ##1 req_ready));

  // R10: abort leaves everything inactive in the next cycle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_abort && !req_ready) |=>
      (fl_ce_n && fl_oe_n && fl_we_n && !fl_alat && !fl_eq && req_ready && !rsp_valid));
endmodule

bind flt_timing_ctrl flt_checker u_flt_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_abort(req_abort), .rsp_valid(rsp_valid), .fl_alat(fl_alat),
  .fl_eq(fl_eq), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/tb_flt_timing_ctrl.sv
module tb_flt_timing_ctrl;
  localparam int AW = 20;
  localparam int CW = 3;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [CW-1:0] cfg_alat, cfg_eq;
  logic [WW-1:0] cfg_wait;
  logic          req_valid, req_ready, req_write, req_wide, req_abort;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic [AW-1:0] fl_addr;
  logic          fl_alat, fl_eq, fl_ce_n, fl_oe_n, fl_we_n, fl_wide;
  logic [31:0]   fl_wdata;
  logic [63:0]   fl_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  // behavioural flash: data derived from address while output-enabled
  assign fl_rdata = fl_oe_n ? 64'h0 : {12'hA5A, fl_addr, 12'h3C3, fl_addr};

  flt_timing_ctrl #(.AW(AW), .CW(CW), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_alat(cfg_alat),
    .cfg_eq(cfg_eq), .cfg_wait(cfg_wait), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_abort(req_abort),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fl_addr(fl_addr),
    .fl_alat(fl_alat), .fl_eq(fl_eq), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_wide(fl_wide), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int a, input int e, input int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_alat = CW'(a); cfg_eq = CW'(e); cfg_wait = WW'(w);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access; checks strobe timing against the fields A/E/W.
  // abort_at > 0: abort in that cycle and check the idle state instead.
  // cfg_at > 0: write new fields (na/ne/nw) in that cycle.
  task automatic do_access(input logic [AW-1:0] addr, input logic [31:0] wd,
                           input bit wr, input bit wide,
                           input int a, input int e, input int w,
                           input int abort_at, input int cfg_at,
                           input int na, input int ne, input int nw,
                           input string tag);
    int alat_first = 0, alat_n = 0, eq_first = 0, eq_n = 0;
    int ce_n = 0, oe_n = 0, we_n = 0, rdy_low = 0, rsp_cyc = 0;
    logic [63:0] got = '0, exp;
    logic [31:0] wseen = '0;
    logic        wideseen = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, {tag, " R9 ready before accept"}, 64'(req_ready), 1);
    req_valid = 1'b1; req_addr = addr; req_wdata = wd;
    req_write = wr; req_wide = wide;
    @(posedge clk);
    for (int c = 1; c <= 60; c++) begin
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0; req_abort = 1'b0;
      if (fl_alat) begin if (alat_first == 0) alat_first = c; alat_n++; end
      if (fl_eq)   begin if (eq_first == 0) eq_first = c; eq_n++; end
      if (!fl_ce_n) ce_n++;
      if (!fl_oe_n) oe_n++;
      if (!fl_we_n) begin we_n++; wseen = fl_wdata; wideseen = fl_wide; end
      if (!req_ready) rdy_low++;
      if (rsp_valid) begin rsp_cyc = c; got = rsp_data; break; end
      if (c == cfg_at) begin
        cfg_we = 1'b1; cfg_alat = CW'(na); cfg_eq = CW'(ne); cfg_wait = WW'(nw);
      end
      if (c == abort_at) begin
        req_abort = 1'b1;
        @(negedge clk);
        req_abort = 1'b0;
        chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_alat && !fl_eq,
            {tag, " R10 strobes idle after abort"},
            {59'h0, fl_ce_n, fl_oe_n, fl_we_n, fl_alat, fl_eq}, 64'h1C);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0,
            {tag, " R10 ready, no response"}, {62'h0, req_ready, rsp_valid}, 64'h2);
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0 && fl_ce_n === 1'b1, {tag, " R10 stays quiet"},
            {62'h0, rsp_valid, fl_ce_n}, 64'h1);
        return;
      end
    end
    chk(alat_first == 1 && alat_n == a + 1, {tag, " R2 latch pulse"},
        64'(alat_n), 64'(a + 1));
    chk(eq_first == a + 2 && eq_n == e + 1, {tag, " R3 equalize pulse"},
        64'(eq_first * 16 + eq_n), 64'((a + 2) * 16 + e + 1));
    chk(rsp_cyc == a + e + w + 4, {tag, " R4 response cycle"},
        64'(rsp_cyc), 64'(a + e + w + 4));
    chk(ce_n == a + e + w + 3, {tag, " R6 chip-enable span"},
        64'(ce_n), 64'(a + e + w + 3));
    chk(rdy_low == a + e + w + 4, {tag, " R9 ready held off"},
        64'(rdy_low), 64'(a + e + w + 4));
    if (wr) begin
      chk(oe_n == 0 && we_n == e + 1 + w, {tag, " R8 write strobes"},
          64'(oe_n * 256 + we_n), 64'(e + 1 + w));
      chk(wseen == (wide ? wd : {16'h0, wd[15:0]}) && wideseen == wide,
          {tag, " R8 program data"}, 64'(wseen), 64'(wide ? wd : {16'h0, wd[15:0]}));
    end else begin
      chk(oe_n == a + e + w + 3 && we_n == 0, {tag, " R6 read strobes"},
          64'(oe_n * 256 + we_n), 64'(a + e + w + 3));
      exp = {12'hA5A, addr, 12'h3C3, addr};
      if (!wide) exp[63:32] = 32'h0;
      chk(got == exp, {tag, " R7 read data"}, got, exp);
    end
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, {tag, " R4 R9 one-cycle response"},
        {62'h0, req_ready, rsp_valid}, 64'h2);
  endtask

  task automatic t_reset;
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_alat && !fl_eq && req_ready && !rsp_valid,
        "R1 reset state",
        {57'h0, fl_ce_n, fl_oe_n, fl_we_n, fl_alat, fl_eq, req_ready, rsp_valid}, 64'h72);
    // R1: reset fields 0/0/15
    do_access(20'h12345, 32'h0, 1'b0, 1'b1, 0, 0, 15, 0, 0, 0, 0, 0, "R1 default read");
  endtask

  task automatic t_reads;
    set_cfg(2, 1, 3);
    do_access(20'h00ABC, 32'h0, 1'b0, 1'b1, 2, 1, 3, 0, 0, 0, 0, 0, "R7 wide read");
    do_access(20'hFEDCB, 32'h0, 1'b0, 1'b0, 2, 1, 3, 0, 0, 0, 0, 0, "R7 narrow read");
  endtask

  task automatic t_independent;
    set_cfg(2, 1, 7);
    do_access(20'h11111, 32'h0, 1'b0, 1'b1, 2, 1, 7, 0, 0, 0, 0, 0, "R5 wait only");
    set_cfg(5, 1, 3);
    do_access(20'h22222, 32'h0, 1'b0, 1'b1, 5, 1, 3, 0, 0, 0, 0, 0, "R5 latch only");
    set_cfg(2, 4, 3);
    do_access(20'h33333, 32'h0, 1'b0, 1'b1, 2, 4, 3, 0, 0, 0, 0, 0, "R5 equalize only");
    set_cfg(7, 7, 0);
    do_access(20'h44444, 32'h0, 1'b0, 1'b0, 7, 7, 0, 0, 0, 0, 0, 0, "R4 zero wait");
  endtask

  task automatic t_writes;
    set_cfg(1, 2, 2);
    do_access(20'h05050, 32'hDEADBEEF, 1'b1, 1'b0, 1, 2, 2, 0, 0, 0, 0, 0, "R8 narrow program");
    do_access(20'h06060, 32'hCAFEF00D, 1'b1, 1'b1, 1, 2, 2, 0, 0, 0, 0, 0, "R8 wide program");
  endtask

  task automatic t_abort;
    set_cfg(2, 1, 3);
    do_access(20'h0A0A0, 32'h0, 1'b0, 1'b1, 2, 1, 3, 1, 0, 0, 0, 0, "R10 abort in latch");
    do_access(20'h0B0B0, 32'h0, 1'b0, 1'b1, 2, 1, 3, 0, 0, 0, 0, 0, "R10 access after latch abort");
    do_access(20'h0C0C0, 32'h0, 1'b1, 1'b1, 2, 1, 3, 4, 0, 0, 0, 0, "R10 abort in equalize");
    do_access(20'h0D0D0, 32'h0, 1'b0, 1'b0, 2, 1, 3, 0, 0, 0, 0, 0, "R10 access after eq abort");
    do_access(20'h0E0E0, 32'h0, 1'b0, 1'b1, 2, 1, 3, 9, 0, 0, 0, 0, "R10 abort in capture");
    do_access(20'h0F0F0, 32'h0, 1'b0, 1'b1, 2, 1, 3, 0, 0, 0, 0, 0, "R10 access after cap abort");
    // R10: abort while idle has no effect on strobes or ready
    @(negedge clk); req_abort = 1'b1;
    @(negedge clk); req_abort = 1'b0;
    chk(req_ready === 1'b1 && fl_ce_n === 1'b1, "R10 idle abort ignored",
        {62'h0, req_ready, fl_ce_n}, 64'h3);
    do_access(20'h10101, 32'h0, 1'b0, 1'b1, 2, 1, 3, 0, 0, 0, 0, 0, "R10 access after idle abort");
  endtask

  task automatic t_cfg_hold;
    do_access(20'h77777, 32'h0, 1'b0, 1'b1, 2, 1, 3, 0, 2, 6, 5, 9, "R11 mid-access write");
    do_access(20'h88888, 32'h0, 1'b0, 1'b1, 6, 5, 9, 0, 0, 0, 0, 0, "R11 new fields apply");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_alat = '0; cfg_eq = '0; cfg_wait = '0;
    req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0; req_abort = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reads();
    t_independent();
    t_writes();
    t_abort();
    t_cfg_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule